// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a bank of performance counters for a memory controller monitor. Slot 0 is a 64-bit cycle counter that advances on every clock. Slots 1 to 10 are 32-bit counters. Each of them watches one line of a shared event vector, picked by a 7-bit code in that slot's control word, and adds one for every clock in which that line is high. A single 32-bit register port with a combinational read path gives software access to a global control word, one control word per slot and the counter values.

Counting can be stopped per slot or for the whole bank. When a counter's top bit goes from 0 to 1 because it counted, and that slot has its condition enable set while the global interrupt enable and the global freeze-on-condition enable are both set, the block raises its interrupt and sets the global freeze bit by itself. The whole bank then stops, so software can read a consistent snapshot. Software clears the condition by releasing the global freeze and clearing the top bit of the counter that overflowed.

Top module: `evb_top`

## Requirements
- R1: After reset every readable register reads 0 and `irq_o` is low.
- R2: Slot 0 is 64 bits wide and adds 1 on every clock in which it is not frozen. Its low word is at 0x58 and its high word at 0x5C, and a carry out of the low word reaches the high word.
- R3: The control word of slot n is at 0x50+0x10·n. Bit 31 is the slot freeze, bit 26 the condition enable and bits 22:16 the event code. All other bits read as 0.
- R4: A 32-bit slot adds 1 in each clock in which `ev_in[code]` is high and it is not frozen. A code of `NUM_EV` or more never advances the counter.
- R5: Setting a slot's freeze bit holds that counter while the other slots keep counting.
- R6: The global control word at 0x40 has bit 31 as the freeze for all slots, bit 30 as the interrupt enable and bit 29 as the freeze-on-condition enable. While bit 31 is set no slot counts, whatever its own freeze bit holds.
- R7: When a count takes a counter's top bit from 0 to 1 and that slot's bit 26, global bit 30 and global bit 29 are all set, `irq_o` goes high on the following clock edge. On that same edge global bit 31 becomes 1, and this overrides a software write in the same cycle.
- R8: If any of those three enables is clear, a top-bit transition neither raises `irq_o` nor sets global bit 31.
- R9: `irq_o` stays high until global bit 31 is 0 and the top bit of the overflowed counter is 0. It falls on the clock edge after both conditions hold.
- R10: A write to a counter word loads the written value even while the counter is frozen. A write takes priority over an increment in the same cycle.
- R11: Writes to the second control offset of a slot (0x54+0x10·n) and to unmapped addresses change nothing, and such addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ev_in | input | NUM_EV (16) | Event lines, one per event code |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
A corrupted count or a wrong event selection shows up in the value read back for that slot on the next read. Comparing every slot against a cycle-accurate reference after each phase exposes it within one phase. A wrong freeze decision shows within a single cycle: a held counter moves, or one that should run stays still. An overflow flag that sets or clears wrongly shows on `irq_o` in the cycle after the edge in question, and `irq_o` is compared with the reference on every cycle.

// File: rtl/evb_pkg.sv
package evb_pkg;

    localparam int DATA_W     = 32;
    localparam int CODE_W     = 7;

    localparam logic [7:0] GLB_ADDR = 8'h40;
    localparam logic [7:0] CNT_BASE = 8'h50;

    // bit positions inside the control words
    localparam int G_FRZ_BIT  = 31;
    localparam int G_IEN_BIT  = 30;
    localparam int G_ARM_BIT  = 29;
    localparam int L_FRZ_BIT  = 31;
    localparam int L_CE_BIT   = 26;
    localparam int L_CODE_LSB = 16;

    // sub-register of a slot, taken from address bits 3:2
    typedef enum logic [1:0] {
        SUB_CTL  = 2'd0,
        SUB_SPR  = 2'd1,
        SUB_LO   = 2'd2,
        SUB_HI   = 2'd3
    } sub_e;

    typedef struct packed {
        logic              frz;
        logic              ce;
        logic [CODE_W-1:0] code;
    } lctl_t;

    typedef struct packed {
        logic frz_all;
        logic ien;
        logic arm;
    } gctl_t;

    function automatic logic [DATA_W-1:0] lctl_word(lctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[L_FRZ_BIT] = c.frz;
        w[L_CE_BIT]  = c.ce;
        w[L_CODE_LSB +: CODE_W] = c.code;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] gctl_word(gctl_t g);
        logic [DATA_W-1:0] w;
        w = '0;
        w[G_FRZ_BIT] = g.frz_all;
        w[G_IEN_BIT] = g.ien;
        w[G_ARM_BIT] = g.arm;
        return w;
    endfunction

endpackage

// File: rtl/evb_global.sv
module evb_global
    import evb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trip_any,
    output gctl_t             g_o
);

    gctl_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (wr) begin
            g_d.frz_all = wdata[G_FRZ_BIT];
            g_d.ien     = wdata[G_IEN_BIT];
            g_d.arm     = wdata[G_ARM_BIT];
        end
        // hardware freeze wins over a same-cycle software write
        if (trip_any) begin
            g_d.frz_all = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign g_o = g_q;

endmodule

// File: rtl/evb_counter.sv
module evb_counter
    import evb_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_EV   = 16,
    parameter bit IS_CYCLE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frz_all,
    input  logic              arm,
    input  logic              wr_ctl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_EV-1:0] ev,
    output lctl_t             ctl_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              trip_o,
    output logic              flag_o
);

    localparam int MSB = CNT_W - 1;

    typedef struct packed {
        lctl_t            ctl;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } st_t;

    st_t  s_d, s_q;
    logic ev_hit;
    logic inc;
    logic run;
    logic trip;
    logic [CNT_W-1:0] bumped;
    logic [63:0]      wide;

    // event select: codes with no connected line stay low
    always_comb begin
        ev_hit = 1'b0;
        for (int i = 0; i < NUM_EV; i++) begin
            if (s_q.ctl.code == CODE_W'(i)) begin
                ev_hit = ev[i];
            end
        end
    end

    always_comb begin
        s_d    = s_q;
        trip   = 1'b0;
        run    = !frz_all && !s_q.ctl.frz;
        inc    = IS_CYCLE ? 1'b1 : ev_hit;
        bumped = s_q.cnt + CNT_W'(1);
        wide   = 64'(s_q.cnt);

        if (wr_lo || wr_hi) begin
            if (wr_lo) wide[31:0]  = wdata;
            if (wr_hi) wide[63:32] = wdata;
            s_d.cnt = wide[CNT_W-1:0];
        end else if (run && inc) begin
            s_d.cnt = bumped;
            if (s_q.ctl.ce && !s_q.cnt[MSB] && bumped[MSB] && arm) begin
                trip = 1'b1;
            end
        end

        if (trip) begin
            s_d.flag = 1'b1;
        end else if (!s_q.cnt[MSB] && !frz_all) begin
            s_d.flag = 1'b0;
        end

        if (wr_ctl) begin
            s_d.ctl.frz  = wdata[L_FRZ_BIT];
            s_d.ctl.ce   = wdata[L_CE_BIT];
            s_d.ctl.code = wdata[L_CODE_LSB +: CODE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_o  = s_q.ctl;
    assign cnt_o  = s_q.cnt;
    assign trip_o = trip;
    assign flag_o = s_q.flag;

endmodule

// File: rtl/evb_top.sv
module evb_top
    import evb_pkg::*;
#(
    parameter int NUM_CNT  = 11,
    parameter int NUM_EV   = 16,
    parameter int ADDR_W   = 8,
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NUM_EV-1:0] ev_in,
    output logic              irq_o
);

    localparam int SLOT_W = ADDR_W - 4;

    gctl_t g_w;
    logic  frz_all_w;
    logic  arm_w;
    logic  glb_sel;
    logic  in_bank;
    logic [ADDR_W-1:0] rel;
    logic [SLOT_W-1:0] slot;
    sub_e              sub;

    logic  [NUM_CNT-1:0]             trip_w;
    logic  [NUM_CNT-1:0]             flag_w;
    logic  [NUM_CNT-1:0]             run_w;
    lctl_t [NUM_CNT-1:0]             ctl_w;
    logic  [NUM_CNT-1:0][DATA_W-1:0] cnt_lo_w;
    logic  [NUM_CNT-1:0][DATA_W-1:0] cnt_hi_w;

    assign glb_sel = (addr == ADDR_W'(GLB_ADDR));
    assign in_bank = (addr >= ADDR_W'(CNT_BASE));
    assign rel     = addr - ADDR_W'(CNT_BASE);
    assign slot    = rel[ADDR_W-1:4];
    assign sub     = sub_e'(rel[3:2]);

    evb_global u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en && glb_sel),
        .wdata    (wdata),
        .trip_any (|trip_w),
        .g_o      (g_w)
    );

    assign frz_all_w = g_w.frz_all;
    assign arm_w     = g_w.ien && g_w.arm;

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
        localparam int W = (n == 0) ? WIDE_W : NARROW_W;
        logic [W-1:0] val;
        logic hit;

        assign hit = wr_en && in_bank && (slot == SLOT_W'(n));

        evb_counter #(
            .CNT_W    (W),
            .NUM_EV   (NUM_EV),
            .IS_CYCLE (n == 0)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .frz_all (frz_all_w),
            .arm     (arm_w),
            .wr_ctl  (hit && sub == SUB_CTL),
            .wr_lo   (hit && sub == SUB_LO),
            .wr_hi   (hit && sub == SUB_HI && (W > 32)),
            .wdata   (wdata),
            .ev      (ev_in),
            .ctl_o   (ctl_w[n]),
            .cnt_o   (val),
            .trip_o  (trip_w[n]),
            .flag_o  (flag_w[n])
        );

        assign cnt_lo_w[n] = val[31:0];
        assign cnt_hi_w[n] = 32'(64'(val) >> 32);
        assign run_w[n]    = !frz_all_w && !ctl_w[n].frz;
    end

    always_comb begin
        rdata = '0;
        if (glb_sel) begin
            rdata = gctl_word(g_w);
        end else if (in_bank && slot < SLOT_W'(NUM_CNT)) begin
            case (sub)
                SUB_CTL: rdata = lctl_word(ctl_w[slot]);
                SUB_LO:  rdata = cnt_lo_w[slot];
                SUB_HI:  rdata = cnt_hi_w[slot];
                default: rdata = '0;
            endcase
        end
    end

    assign irq_o = |flag_w;

endmodule

// File: rtl/evb_chk.sv
module evb_chk #(
    parameter int NUM_CNT = 11
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic                     irq_o,
    input logic                     frz_all,
    input logic                     arm,
    input logic [NUM_CNT-1:0]       run,
    input logic [NUM_CNT-1:0][31:0] cnt_lo
);

    // R7: interrupt rise comes with the bank frozen
    a_r7_irq_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> frz_all);

    // R8: interrupt rises only if both global enables were set
    a_r8_irq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(arm));

    // R9: interrupt cannot drop while the bank is frozen
    a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && frz_all) |=> irq_o);

    // R6: a frozen bank with no writes keeps every low word
    a_r6_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_all && !wr_en) |=> $stable(cnt_lo));

    // R2: the cycle counter advances by one when running
    a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run[0] && !wr_en) |=> (cnt_lo[0] == $past(cnt_lo[0]) + 32'd1));

endmodule

bind evb_top evb_chk #(.NUM_CNT(NUM_CNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .irq_o   (irq_o),
    .frz_all (frz_all_w),
    .arm     (arm_w),
    .run     (run_w),
    .cnt_lo  (cnt_lo_w)
);

// File: tb/tb_evb_top.sv
module tb_evb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CNT    = 11;
    localparam int NUM_EV     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NUM_EV-1:0] ev_in = '0;
    logic              irq_o;

    int checks = 0;
    int errs   = 0;
    bit mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evb_top #(.NUM_CNT(NUM_CNT), .NUM_EV(NUM_EV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_in(ev_in), .irq_o(irq_o)
    );

    // ---------------- reference model built from the requirements
    logic [63:0] m_cnt  [NUM_CNT];
    bit          m_fc   [NUM_CNT];
    bit          m_ce   [NUM_CNT];
    logic [6:0]  m_code [NUM_CNT];
    bit          m_flag [NUM_CNT];
    bit          m_fac, m_ien, m_arm;

    function automatic bit top_bit(int n, logic [63:0] v);
        return (n == 0) ? v[63] : v[31];
    endfunction

    function automatic logic [63:0] trim(int n, logic [63:0] v);
        return (n == 0) ? v : {32'd0, v[31:0]};
    endfunction

    function automatic logic [31:0] ctl_exp(int n);
        logic [31:0] w;
        w = '0;
        w[31] = m_fc[n];
        w[26] = m_ce[n];
        w[22:16] = m_code[n];
        return w;
    endfunction

    function automatic bit m_irq();
        bit r;
        r = 1'b0;
        for (int n = 0; n < NUM_CNT; n++) r |= m_flag[n];
        return r;
    endfunction

    always @(posedge clk) begin : mdl
        logic [63:0] nc [NUM_CNT];
        bit          nf [NUM_CNT];
        bit          trip;
        bit          tn, run, inc, wlo, whi;
        if (!rst_n) begin
            for (int n = 0; n < NUM_CNT; n++) begin
                m_cnt[n] = '0; m_fc[n] = 0; m_ce[n] = 0; m_code[n] = '0; m_flag[n] = 0;
            end
            m_fac = 0; m_ien = 0; m_arm = 0;
        end else begin
            trip = 1'b0;
            for (int n = 0; n < NUM_CNT; n++) begin
                tn  = 1'b0;
                run = !m_fac && !m_fc[n];
                inc = (n == 0) ? 1'b1 : ((m_code[n] < NUM_EV) ? ev_in[m_code[n][3:0]] : 1'b0);
                wlo = wr_en && (addr == 8'(8'h58 + 16 * n));
                whi = wr_en && (n == 0) && (addr == 8'h5C);
                nc[n] = m_cnt[n];
                if (wlo || whi) begin
                    if (wlo) nc[n][31:0]  = wdata;
                    if (whi) nc[n][63:32] = wdata;
                end else if (run && inc) begin
                    nc[n] = trim(n, m_cnt[n] + 64'd1);
                    tn = m_ce[n] && !top_bit(n, m_cnt[n]) && top_bit(n, nc[n]) && m_ien && m_arm;
                end
                nf[n] = m_flag[n];
                if (tn) nf[n] = 1'b1;
                else if (!top_bit(n, m_cnt[n]) && !m_fac) nf[n] = 1'b0;
                trip |= tn;
            end
            for (int n = 0; n < NUM_CNT; n++) begin
                m_cnt[n]  = nc[n];
                m_flag[n] = nf[n];
                if (wr_en && addr == 8'(8'h50 + 16 * n)) begin
                    m_fc[n] = wdata[31]; m_ce[n] = wdata[26]; m_code[n] = wdata[22:16];
                end
            end
            if (wr_en && addr == 8'h40) begin
                m_fac = wdata[31]; m_ien = wdata[30]; m_arm = wdata[29];
            end
            if (trip) m_fac = 1'b1;
        end
    end

    // ---------------- helpers
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R7 R8 R9: interrupt compared with the model every cycle
    always @(negedge clk) begin
        if (mon_on) chk("R9 irq level", 32'(irq_o), 32'(m_irq()));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic spin(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_in = NUM_EV'($urandom());
        end
    endtask

    task automatic compare_all();
        logic [31:0] v;
        for (int n = 0; n < NUM_CNT; n++) begin
            rd(8'(8'h50 + 16 * n), v);
            chk("R3 control word", v, ctl_exp(n));
            rd(8'(8'h58 + 16 * n), v);
            chk(n == 0 ? "R2 cycle low" : "R4 event count", v, m_cnt[n][31:0]);
            if (n == 0) begin
                rd(8'h5C, v);
                chk("R2 cycle high", v, m_cnt[0][63:32]);
            end
        end
        rd(8'h40, v);
        chk("R6 global word", v, {m_fac, m_ien, m_arm, 29'd0});
    endtask

    // ---------------- watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // ---------------- stimulus
    initial begin
        logic [31:0] v, v2;
        int waited;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 irq after reset", 32'(irq_o), 32'd0);
        compare_all();
        mon_on = 1'b1;

        // R4 random event counting; slot 9 gets an unconnected code
        for (int n = 1; n < NUM_CNT; n++) begin
            if (n == 9) wr(8'(8'h50 + 16 * n), 32'(100) << 16);
            else        wr(8'(8'h50 + 16 * n), 32'($urandom_range(0, NUM_EV - 1)) << 16);
        end
        spin(300);
        compare_all();
        rd(8'hE8, v);
        chk("R4 unconnected code stays zero", v, 32'd0);

        // R5: slot 3 frozen alone
        wr(8'h80, 32'h8000_0000 | (32'd1 << 16));
        rd(8'h88, v);
        spin(40);
        rd(8'h88, v2);
        chk("R5 frozen slot holds", v2, v);
        compare_all();

        // R6: global freeze overrides a clear local freeze
        wr(8'h80, 32'd1 << 16);
        wr(8'h40, 32'h8000_0000);
        rd(8'h58, v);
        spin(30);
        rd(8'h58, v2);
        chk("R6 cycle counter frozen", v2, v);
        compare_all();

        // R10: load while frozen
        wr(8'h98, 32'h0000_1234);
        rd(8'h98, v);
        chk("R10 load while frozen", v, 32'h0000_1234);

        // R2: carry into the high word
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h5C, 32'h0000_0007);
        rd(8'h5C, v);
        chk("R2 high word load", v, 32'h0000_0007);
        wr(8'h40, 32'h0);
        rd(8'h58, v);
        chk("R2 low word wrap", v, 32'h0000_0000);
        rd(8'h5C, v);
        chk("R2 carry to high word", v, 32'h0000_0008);

        // R7: overflow on slot 5 with all enables set
        ev_in = 16'h0004;
        wr(8'h40, 32'h8000_0000);
        wr(8'hA0, 32'h0400_0000 | (32'd2 << 16));
        wr(8'hA8, 32'h7FFF_FFFE);
        wr(8'h40, 32'h6000_0000);
        waited = 0;
        while (!irq_o && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        chk("R7 irq raised", 32'(irq_o), 32'd1);
        rd(8'h40, v);
        chk("R7 hardware freeze set", v, 32'hE000_0000);
        rd(8'hA8, v);
        chk("R7 counter stops at top bit", v, 32'h8000_0000);
        rd(8'h58, v);
        rd(8'h58, v2);
        chk("R7 whole bank frozen", v2, v);

        // R9: release the freeze only, then clear the top bit
        wr(8'h40, 32'h6000_0000);
        spin(0);
        @(negedge clk);
        chk("R9 irq held while top bit set", 32'(irq_o), 32'd1);
        wr(8'hA8, 32'h0);
        @(negedge clk);
        chk("R9 irq released", 32'(irq_o), 32'd0);

        // R8: no condition enable on slot 6
        wr(8'hB0, 32'd2 << 16);
        wr(8'hB8, 32'h7FFF_FFFF);
        repeat (3) @(negedge clk);
        rd(8'h40, v);
        chk("R8 no freeze without slot enable", v, 32'h6000_0000);
        chk("R8 no irq without slot enable", 32'(irq_o), 32'd0);
        // R8: slot enable set but global interrupt enable clear
        wr(8'h40, 32'h2000_0000);
        wr(8'hC0, 32'h0400_0000 | (32'd2 << 16));
        wr(8'hC8, 32'h7FFF_FFFF);
        repeat (3) @(negedge clk);
        rd(8'h40, v);
        chk("R8 no freeze without interrupt enable", v, 32'h2000_0000);
        chk("R8 no irq without interrupt enable", 32'(irq_o), 32'd0);

        // R11: spare control offset and unmapped address
        wr(8'h94, 32'hFFFF_FFFF);
        rd(8'h94, v);
        chk("R11 spare offset reads zero", v, 32'd0);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, v);
        chk("R11 unmapped reads zero", v, 32'd0);
        compare_all();

        // R10: write beats a same-cycle increment
        wr(8'h68, 32'h0000_0055);
        rd(8'h68, v);
        chk("R10 write wins over increment", v, m_cnt[1][31:0]);

        // mixed random phase with enables
        wr(8'h40, 32'h6000_0000);
        for (int r = 0; r < 4; r++) begin
            for (int n = 1; n < NUM_CNT; n++) begin
                wr(8'(8'h50 + 16 * n), ($urandom() & 32'h8400_0000) | (32'($urandom_range(0, 20)) << 16));
            end
            spin(150);
            compare_all();
        end

        mon_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule